// File: doc/BRIEF.md
# Circular Receive Channel with Occupancy Accounting

This block is one receive channel of a network-to-memory DMA engine. Its memory area is a circular buffer, not a fixed-size packet. Software first stages a base address, a region length in words and a bus address to listen for. It then fires an init strobe, and the channel captures those three values. After that the channel pops words from the receive FIFO of the interconnect.

An address word equal to the listen address opens reception. Every data word after it is written through a single write port, to consecutive locations in the region, wrapping back to the base after the last location. Any other address word closes reception, and the data words behind it are drained and dropped.

The channel counts the words it has taken and software has not yet released. Software releases space by writing the number of words it has consumed on the acknowledge input. When the count reaches the region length, the channel stops popping the FIFO until an acknowledge frees room. A sticky interrupt flag reports that new data reached memory since software last cleared it.

Top module: `ringrx_stream_chan`

## Requirements
- R1: After reset `rx_re`, `mem_we` and `irq` are 0 and `fill_count` is 0, and the channel never asserts `rx_re` before its first init strobe.
- R2: `cfg_base`, `cfg_len` and `cfg_listen` are captured only in a cycle with `init_pulse`=1. Changing them at any other time does not alter the write addresses or the listen address in use. Init also clears the occupancy to 0 and restarts writing at the base.
- R3: A FIFO word with `rx_addr_valid`=1 is an address word. It is popped and never written to memory. If its low ADDR_W bits equal the captured listen address, the data words that follow are taken. Otherwise they are popped and discarded, and neither written nor counted.
- R4: The k-th data word taken since init (k from 0) is written with `mem_addr` = base + (k mod length), with data unchanged and in arrival order.
- R5: `fill_count` rises by one in the cycle after each data word is taken. A cycle with `ack_we`=1 lowers it by `ack_words`, saturating at 0. A take and an acknowledge in the same cycle change it by their net difference.
- R6: While `fill_count` equals the captured length, `rx_re` stays 0 until an acknowledge frees space. A length of 0 therefore never reads. No word is popped in an init cycle.
- R7: A pending memory write holds `mem_we`, `mem_addr` and `mem_data` stable while `mem_wait`=1. A write completes on a clock edge where `mem_we`=1 and `mem_wait`=0.
- R8: `irq` becomes 1 in the cycle after a memory write completes. `irq_clr`=1 clears it, but only in a cycle in which no write completes, so a completing write wins.
- R9: Acknowledges before the first init have no effect. In a cycle that has both init and acknowledge, init wins.
- R10: Once initialised, when the FIFO is not empty, `fill_count` is below the length and the write port is not stalled (`mem_we`=0 or `mem_wait`=0), `rx_re` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| init_pulse | input | 1 | Capture staged settings and restart the channel |
| cfg_base | input | ADDR_W | Staged region base address |
| cfg_len | input | WORDS_W | Staged region length in words |
| cfg_listen | input | ADDR_W | Staged bus address to accept |
| ack_we | input | 1 | Software consumption acknowledge strobe |
| ack_words | input | WORDS_W | Number of words consumed |
| irq_clr | input | 1 | Clear the interrupt flag |
| rx_data | input | DATA_W | FIFO head word |
| rx_addr_valid | input | 1 | FIFO head is an address word |
| rx_empty | input | 1 | FIFO has no word |
| rx_re | output | 1 | Pop the FIFO head |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write request |
| mem_wait | input | 1 | Memory stalls the request |
| fill_count | output | WORDS_W | Words taken and not yet acknowledged |
| irq | output | 1 | New data written since last clear |

## Verification
The bench fills the ring to exactly its length and checks that the channel stalls. A design with an off-by-one full test would either overwrite unread data or stop one word early and leave a word stranded in the FIFO. It checks the wrap-around addresses after a partial acknowledge and an oversized acknowledge that must saturate at zero; a missing wrap writes past the region, and a missing saturation leaves a huge bogus count. Random acknowledges landing in the same cycle as takes catch an occupancy update that loses one of the two. Interleaved non-matching address streams, a zero-length init, staged-setting changes without init and interrupt clears that race a completing write cover the filter, capture and flag priorities.

// File: rtl/ringrx_pkg.sv
package ringrx_pkg;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_HUNT = 2'd1,
        CH_TAKE = 2'd2
    } ch_state_e;

    // next offset inside a ring of len words
    function automatic logic [31:0] ring_advance(logic [31:0] off, logic [31:0] len);
        logic [31:0] nxt;
        nxt = off + 32'd1;
        return (nxt >= len) ? 32'd0 : nxt;
    endfunction

    // occupancy after one optional increment and one optional release, floor 0
    function automatic logic [32:0] occ_net(logic [31:0] cur, logic inc,
                                            logic rel_en, logic [31:0] rel);
        logic [32:0] sum;
        sum = {1'b0, cur} + {32'd0, inc};
        if (rel_en) begin
            if (sum > {1'b0, rel}) sum = sum - {1'b0, rel};
            else                   sum = 33'd0;
        end
        return sum;
    endfunction

endpackage

// File: rtl/ringrx_cfg_latch.sv
module ringrx_cfg_latch #(
    parameter int ADDR_W  = 16,
    parameter int WORDS_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               init_pulse,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [WORDS_W-1:0] cfg_len,
    input  logic [ADDR_W-1:0]  cfg_listen,
    output logic [ADDR_W-1:0]  base_q,
    output logic [WORDS_W-1:0] len_q,
    output logic [ADDR_W-1:0]  listen_q,
    output logic               active_q
);
    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [WORDS_W-1:0] len;
        logic [ADDR_W-1:0]  listen;
        logic               active;
    } ring_cfg_t;

    ring_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (init_pulse) begin
            cfg_q.base   <= cfg_base;
            cfg_q.len    <= cfg_len;
            cfg_q.listen <= cfg_listen;
            cfg_q.active <= 1'b1;
        end
    end

    assign base_q   = cfg_q.base;
    assign len_q    = cfg_q.len;
    assign listen_q = cfg_q.listen;
    assign active_q = cfg_q.active;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !init_pulse |=> ($stable(len_q) && $stable(base_q) && $stable(listen_q))); // R2

endmodule

// File: rtl/ringrx_accept.sv
module ringrx_accept
    import ringrx_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_pulse,
    input  logic [ADDR_W-1:0] listen_q,
    input  logic [ADDR_W-1:0] rx_addr_bits,
    input  logic              rx_addr_valid,
    input  logic              rx_empty,
    input  logic              room,
    input  logic              stage_free,
    output logic              rx_re,
    output logic              take_word
);
    ch_state_e state_q, state_d;
    logic      pop;

    always_comb begin
        pop = 1'b0;
        if (state_q != CH_OFF && !init_pulse && !rx_empty && room) begin
            pop = rx_addr_valid || (state_q == CH_HUNT) || stage_free;
        end
    end

    always_comb begin
        state_d = state_q;
        if (init_pulse) begin
            state_d = CH_HUNT;
        end else if (pop && rx_addr_valid) begin
            state_d = (rx_addr_bits == listen_q) ? CH_TAKE : CH_HUNT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CH_OFF;
        else     state_q <= state_d;
    end

    assign rx_re     = pop;
    assign take_word = pop && !rx_addr_valid && (state_q == CH_TAKE);

    AST_OFF_QUIET:     assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_OFF) |-> !rx_re); // R1
    AST_ADDR_NOT_DATA: assert property (@(posedge clk) disable iff (rst)
        (rx_re && rx_addr_valid) |-> !take_word); // R3
    AST_INIT_NO_POP:   assert property (@(posedge clk) disable iff (rst)
        init_pulse |-> !rx_re); // R6

endmodule

// File: rtl/ringrx_occupancy.sv
module ringrx_occupancy
    import ringrx_pkg::*;
#(
    parameter int WORDS_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               init_pulse,
    input  logic               active_q,
    input  logic [WORDS_W-1:0] len_q,
    input  logic               take_word,
    input  logic               ack_we,
    input  logic [WORDS_W-1:0] ack_words,
    output logic [WORDS_W-1:0] occ_q,
    output logic               room
);
    logic [WORDS_W-1:0] occ_d;

    always_comb begin
        occ_d = occ_q;
        if (init_pulse) begin
            occ_d = '0;
        end else if (active_q) begin
            occ_d = WORDS_W'(occ_net(32'(occ_q), take_word, ack_we, 32'(ack_words)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) occ_q <= '0;
        else     occ_q <= occ_d;
    end

    assign room = (occ_q < len_q);

    AST_OCC_BOUND:  assert property (@(posedge clk) disable iff (rst)
        occ_q <= len_q); // R5
    AST_NET_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (active_q && !init_pulse && take_word && ack_we &&
         ({1'b0, occ_q} + 1'b1 > {1'b0, ack_words}))
        |=> (occ_q == WORDS_W'($past(occ_q) + 1'b1 - $past(ack_words)))); // R5
    AST_ACK_FLOOR:  assert property (@(posedge clk) disable iff (rst)
        (active_q && !init_pulse && !take_word && ack_we && (ack_words >= occ_q))
        |=> (occ_q == '0)); // R5

endmodule

// File: rtl/ringrx_wr_port.sv
module ringrx_wr_port
    import ringrx_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 16,
    parameter int WORDS_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               init_pulse,
    input  logic [ADDR_W-1:0]  base_q,
    input  logic [WORDS_W-1:0] len_q,
    input  logic               take_word,
    input  logic [DATA_W-1:0]  rx_data,
    input  logic               mem_wait,
    input  logic               irq_clr,
    output logic               stage_free,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_data,
    output logic               mem_we,
    output logic               irq
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    wr_req_t            req_q;
    logic [WORDS_W-1:0] off_q;
    logic               irq_q;
    logic               done;

    assign done       = req_q.vld && !mem_wait;
    assign stage_free = !req_q.vld || !mem_wait;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= '0;
        end else if (init_pulse) begin
            off_q <= '0;
        end else if (take_word) begin
            off_q <= WORDS_W'(ring_advance(32'(off_q), 32'(len_q)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (take_word) begin
            req_q.vld  <= 1'b1;
            req_q.addr <= base_q + ADDR_W'(off_q);
            req_q.data <= rx_data;
        end else if (done) begin
            req_q.vld <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          irq_q <= 1'b0;
        else if (done)    irq_q <= 1'b1;
        else if (irq_clr) irq_q <= 1'b0;
    end

    assign mem_addr = req_q.addr;
    assign mem_data = req_q.data;
    assign mem_we   = req_q.vld;
    assign irq      = irq_q;

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_wait) |=> (mem_we && $stable(mem_addr) && $stable(mem_data))); // R7
    AST_NO_CLOBBER: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_wait) |-> !take_word); // R7
    AST_IRQ_SET:    assert property (@(posedge clk) disable iff (rst)
        (mem_we && !mem_wait) |=> irq); // R8

endmodule

// File: rtl/ringrx_stream_chan.sv
module ringrx_stream_chan
    import ringrx_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 16,
    parameter int WORDS_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               init_pulse,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [WORDS_W-1:0] cfg_len,
    input  logic [ADDR_W-1:0]  cfg_listen,
    input  logic               ack_we,
    input  logic [WORDS_W-1:0] ack_words,
    input  logic               irq_clr,
    input  logic [DATA_W-1:0]  rx_data,
    input  logic               rx_addr_valid,
    input  logic               rx_empty,
    output logic               rx_re,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_data,
    output logic               mem_we,
    input  logic               mem_wait,
    output logic [WORDS_W-1:0] fill_count,
    output logic               irq
);
    logic [ADDR_W-1:0]  base_q;
    logic [WORDS_W-1:0] len_q;
    logic [ADDR_W-1:0]  listen_q;
    logic               active_q;
    logic               room;
    logic               stage_free;
    logic               take_word;

    ringrx_cfg_latch #(.ADDR_W(ADDR_W), .WORDS_W(WORDS_W)) u_cfg (
        .clk(clk), .rst(rst), .init_pulse(init_pulse),
        .cfg_base(cfg_base), .cfg_len(cfg_len), .cfg_listen(cfg_listen),
        .base_q(base_q), .len_q(len_q), .listen_q(listen_q), .active_q(active_q)
    );

    ringrx_accept #(.ADDR_W(ADDR_W)) u_accept (
        .clk(clk), .rst(rst), .init_pulse(init_pulse), .listen_q(listen_q),
        .rx_addr_bits(rx_data[ADDR_W-1:0]), .rx_addr_valid(rx_addr_valid),
        .rx_empty(rx_empty), .room(room), .stage_free(stage_free),
        .rx_re(rx_re), .take_word(take_word)
    );

    ringrx_occupancy #(.WORDS_W(WORDS_W)) u_occ (
        .clk(clk), .rst(rst), .init_pulse(init_pulse), .active_q(active_q),
        .len_q(len_q), .take_word(take_word), .ack_we(ack_we),
        .ack_words(ack_words), .occ_q(fill_count), .room(room)
    );

    ringrx_wr_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS_W(WORDS_W)) u_wr (
        .clk(clk), .rst(rst), .init_pulse(init_pulse), .base_q(base_q),
        .len_q(len_q), .take_word(take_word), .rx_data(rx_data),
        .mem_wait(mem_wait), .irq_clr(irq_clr), .stage_free(stage_free),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_we(mem_we), .irq(irq)
    );

    AST_FULL_STALL:  assert property (@(posedge clk) disable iff (rst)
        (fill_count == len_q) |-> !rx_re); // R6
    AST_PRE_INIT:    assert property (@(posedge clk) disable iff (rst)
        !active_q |-> (!rx_re && fill_count == '0)); // R9
    AST_TAKE_COUNTS: assert property (@(posedge clk) disable iff (rst)
        (take_word && !ack_we) |=> (fill_count == $past(fill_count) + 1'b1)); // R5

endmodule

// File: tb/test_ringrx_stream_chan.sv
module test_ringrx_stream_chan;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 16;
    localparam int WORDS_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic init_pulse = 1'b0;
    logic [ADDR_W-1:0]  cfg_base = '0;
    logic [WORDS_W-1:0] cfg_len = '0;
    logic [ADDR_W-1:0]  cfg_listen = '0;
    logic ack_we = 1'b0;
    logic [WORDS_W-1:0] ack_words = '0;
    logic irq_clr = 1'b0;
    logic [DATA_W-1:0] rx_data = '0;
    logic rx_addr_valid = 1'b0;
    logic rx_empty = 1'b1;
    logic rx_re;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_data;
    logic mem_we;
    logic mem_wait = 1'b0;
    logic [WORDS_W-1:0] fill_count;
    logic irq;

    always #5 clk = ~clk;

    ringrx_stream_chan #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS_W(WORDS_W)) i_ringrx_stream_chan (
        .clk(clk), .rst(rst), .init_pulse(init_pulse), .cfg_base(cfg_base),
        .cfg_len(cfg_len), .cfg_listen(cfg_listen), .ack_we(ack_we),
        .ack_words(ack_words), .irq_clr(irq_clr), .rx_data(rx_data),
        .rx_addr_valid(rx_addr_valid), .rx_empty(rx_empty), .rx_re(rx_re),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_we(mem_we),
        .mem_wait(mem_wait), .fill_count(fill_count), .irq(irq)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [32:0] fifo_q[$];
    int exp_addr[$];
    int exp_data[$];
    int  occ_m = 0, len_m = 0, base_m = 0, listen_m = 0, idx_m = 0;
    bit  active_m = 0, matched_m = 0, irq_m = 0;
    int  seed_v;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input bit av, input int v);
        fifo_q.push_back({av, 32'(v)});
    endtask

    function automatic int chk_wait(input int pct);
        return (($urandom % 100) < pct) ? 1 : 0;
    endfunction

    // one clock cycle; called at a falling edge, returns at the next falling edge
    task automatic step(input bit do_init, input bit do_ack, input int ack_n,
                        input bit do_clr, input int wait_pct);
        bit pop, wr, take;
        logic [32:0] head;
        int s;
        init_pulse = do_init;
        ack_we     = do_ack;
        ack_words  = WORDS_W'(ack_n);
        irq_clr    = do_clr;
        mem_wait   = chk_wait(wait_pct) != 0;
        if (fifo_q.size() > 0) begin
            head = fifo_q[0];
            rx_empty = 1'b0;
            rx_addr_valid = head[32];
            rx_data = head[31:0];
        end else begin
            head = '0;
            rx_empty = 1'b1;
            rx_addr_valid = 1'b0;
            rx_data = '0;
        end
        #1;
        pop = rx_re;
        wr  = mem_we && !mem_wait;
        if (rx_re)
            chk(active_m && !do_init && occ_m < len_m && fifo_q.size() > 0,
                "R6 pop only with room", occ_m, len_m);
        if (active_m && !do_init && occ_m < len_m && fifo_q.size() > 0 && (!mem_we || !mem_wait))
            chk(rx_re == 1'b1, "R10 no false stall", rx_re, 1);
        if (wr) begin
            if (exp_addr.size() == 0) begin
                chk(0, "R4 unexpected write", mem_addr, -1);
            end else begin
                chk(mem_addr == ADDR_W'(exp_addr[0]), "R4 write address", mem_addr, exp_addr[0]);
                chk(mem_data == DATA_W'(exp_data[0]), "R3 write data", mem_data, exp_data[0]);
                void'(exp_addr.pop_front());
                void'(exp_data.pop_front());
            end
        end
        // model update
        if (wr) irq_m = 1;
        else if (do_clr) irq_m = 0;
        take = 0;
        if (pop) begin
            void'(fifo_q.pop_front());
            if (head[32]) matched_m = (head[ADDR_W-1:0] == ADDR_W'(listen_m));
            else if (matched_m) take = 1;
        end
        if (take) begin
            exp_addr.push_back((base_m + (idx_m % len_m)) & 16'hFFFF);
            exp_data.push_back(int'(head[31:0]));
            idx_m++;
        end
        if (do_init) begin
            occ_m = 0; idx_m = 0; active_m = 1; matched_m = 0;
            base_m = int'(cfg_base); len_m = int'(cfg_len); listen_m = int'(cfg_listen);
        end else if (active_m) begin
            s = occ_m + (take ? 1 : 0);
            if (do_ack) s = (s > ack_n) ? s - ack_n : 0;
            occ_m = s;
        end
        @(negedge clk);
        chk(fill_count == WORDS_W'(occ_m), "R5 fill count", fill_count, occ_m);
        chk(irq == irq_m, "R8 irq flag", irq, irq_m);
        init_pulse = 0; ack_we = 0; irq_clr = 0;
    endtask

    task automatic idle(input int n, input int wait_pct);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, wait_pct);
    endtask

    task automatic drain();
        for (int i = 0; i < 300 && (fifo_q.size() > 0 || exp_addr.size() > 0 || mem_we); i++)
            step(0, occ_m > 0, occ_m, 0, 20);
        chk(fifo_q.size() == 0 && !mem_we, "R10 drained", fifo_q.size(), 0);
    endtask

    task automatic do_init(input int b, input int l, input int lis);
        cfg_base = ADDR_W'(b); cfg_len = WORDS_W'(l); cfg_listen = ADDR_W'(lis);
        step(1, 0, 0, 0, 0);
    endtask

    initial begin
        seed_v = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        chk(rx_re == 0 && mem_we == 0, "R1 outputs quiet in reset", {rx_re, mem_we}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(fill_count == 0, "R1 fill after reset", fill_count, 0);
        chk(irq == 0, "R1 irq after reset", irq, 0);

        // traffic and acks before any init
        push(1, 16'h55); push(0, 32'hAAAA0001);
        step(0, 1, 5, 0, 0);
        idle(4, 0);
        chk(fifo_q.size() == 2, "R9 no read before init", fifo_q.size(), 2);
        chk(fill_count == 0, "R9 ack ignored before init", fill_count, 0);
        fifo_q.delete();

        // init + ack same cycle: init wins
        cfg_base = 16'h0100; cfg_len = 8'd8; cfg_listen = 16'h0055;
        step(1, 1, 3, 0, 0);
        // staged values change without init: must be ignored
        cfg_base = 16'h0999; cfg_len = 8'd3; cfg_listen = 16'h0077;

        push(1, 16'h55);
        for (int i = 0; i < 5; i++) push(0, 32'hD000_0000 + i);
        push(1, 16'h77);
        for (int i = 0; i < 3; i++) push(0, 32'hBAD0_0000 + i);
        push(1, 16'h55);
        for (int i = 0; i < 6; i++) push(0, 32'hD100_0000 + i);
        idle(60, 30);
        chk(fill_count == 8, "R6 ring fills to length", fill_count, 8);
        chk(fifo_q.size() == 3, "R6 stall leaves words queued", fifo_q.size(), 3);
        chk(rx_re == 0, "R6 read held low when full", rx_re, 0);

        step(0, 1, 3, 0, 0);
        idle(30, 30);
        chk(fifo_q.size() == 0, "R4 wrapped words taken", fifo_q.size(), 0);
        chk(fill_count == 8, "R5 refilled after ack", fill_count, 8);
        chk(exp_addr.size() == 0, "R4 all writes seen", exp_addr.size(), 0);

        step(0, 1, 200, 0, 0);
        chk(fill_count == 0, "R5 oversized ack saturates", fill_count, 0);

        step(0, 0, 0, 1, 0);
        chk(irq == 0, "R8 clear without write", irq, 0);

        // re-init with new area
        drain();
        do_init(16'h0040, 5, 16'h0003);
        push(1, 3);
        for (int i = 0; i < 12; i++) push(0, 32'hC000_0000 + i);
        for (int i = 0; i < 80; i++) step(0, (i % 3) == 0 && occ_m > 0, 2, (i % 7) == 0, 40);
        drain();

        // zero length: never reads
        do_init(16'h0300, 0, 16'h0009);
        push(1, 9); push(0, 32'h1234);
        idle(10, 0);
        chk(fifo_q.size() == 2, "R6 zero length never reads", fifo_q.size(), 2);
        fifo_q.delete();

        // random phase
        do_init(16'h0200, 6, 16'h0012);
        for (int i = 0; i < 3000; i++) begin
            if (fifo_q.size() < 16 && ($urandom % 100) < 45) begin
                if (($urandom % 100) < 15) push(1, (($urandom % 3) == 0) ? 16'h13 : 16'h12);
                else push(0, int'($urandom));
            end
            step(0, ($urandom % 100) < 20, int'($urandom % 4), ($urandom % 100) < 10, 25);
        end
        drain();

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule